// File: doc/BRIEF.md
# SIMD Lane Execution Mask Controller

This block keeps the per-lane execution mask and the per-lane condition mask of a 64-lane wavefront. The lanes are handled as four groups of 16. Divergent if/else control flow is built from explicit scalar mask instructions. A compare result is loaded into the condition mask. The current mask is copied into a save slot. The mask is narrowed to the "if" lanes, then flipped to the "else" lanes against the saved copy, and at the join it is put back from the save slot. There is no hidden reconvergence stack.

A branch unit uses two all-zero flags and a branch-decision output to skip an "if" body when no lane passes the compare, and to skip an "else" body when no lane is left for it. The block also gates the per-lane write enables of a small vector register bank, so that only active lanes take new data. Instructions arrive already decoded, as a 4-bit opcode plus a save-slot select. Fetch, arithmetic and memory access are handled elsewhere.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset, `execMask` is all ones, `vccMask` is all zeros and every lane register reads zero.
- R2: Opcode 1, the compare load, sets `vccMask` to `cmpBits & execMask` on the next cycle. Inactive lanes therefore read 0.
- R3: Opcode 2 copies `execMask` into the save slot chosen by `saveSel`. The copy is seen later only through opcodes 4 and 5.
- R4: Opcode 3, the "if" narrowing, sets `execMask` to `vccMask & execMask` on the next cycle.
- R5: Opcode 4, the "else" flip, sets `execMask` to `slot[saveSel] & ~execMask` on the next cycle.
- R6: Opcode 5, the restore, sets `execMask` to `slot[saveSel]` on the next cycle.
- R7: While opcode 6 is presented, `branchTake` is 1 in that same cycle exactly when `vccMask` is all zero.
- R8: While opcode 7 is presented, `branchTake` is 1 in that same cycle exactly when `execMask` is all zero.
- R9: While opcode 8 is presented, `laneWbEn` equals `execMask` in that same cycle. On the next cycle, lane i of `laneRegs` (bits i*8 up to i*8+7) takes lane i of `laneData` where the exec bit is 1, and keeps its old value where the exec bit is 0.
- R10: `vccZero` and `execZero` are 1 exactly when the matching mask is all zero.
- R11: Idle cycles (`instValid` low) and opcodes 0 and 9 to 15 change no state. In those cycles `branchTake` and `laneWbEn` stay 0.
- R12: The two save slots (`saveSel` 0 and 1) are independent, so one nested level can be saved and restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present this cycle |
| opcode | input | 4 | Decoded operation code |
| saveSel | input | 1 | Save-slot index |
| cmpBits | input | 64 | Per-lane compare result |
| laneData | input | 512 | Per-lane write data, 8 bits per lane |
| execMask | output | 64 | Current execution mask |
| vccMask | output | 64 | Current condition mask |
| vccZero | output | 1 | Condition mask is all zero |
| execZero | output | 1 | Execution mask is all zero |
| branchTake | output | 1 | Skip decision for a branch opcode |
| laneWbEn | output | 64 | Gated per-lane write enables |
| laneRegs | output | 512 | Lane register bank contents |

## Verification
`branchTake` and `laneWbEn` are combinational. The bench samples them 1 ns after it drives an instruction, while the pre-instruction state is still in place. Mask updates, save slots and lane registers are due after exactly one clock edge, so they are sampled 1 ns after that edge and compared with a bench model that was advanced at the same edge. Save-slot contents are checked only through later restore and "else" instructions, and the flags are checked after every instruction.

// File: rtl/lmask_pkg.sv
package lmask_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_VCMP     = 4'd1,
    OP_SAVE     = 4'd2,
    OP_IFAND    = 4'd3,
    OP_ELSEANDN = 4'd4,
    OP_RESTORE  = 4'd5,
    OP_BRVCCZ   = 4'd6,
    OP_BREXECZ  = 4'd7,
    OP_VWRITE   = 4'd8
  } opE;

  // strobes from decode to the mask datapath
  typedef struct packed {
    logic vccLoad;
    logic saveLoad;
    logic execIf;
    logic execElse;
    logic execRestore;
    logic laneWrite;
    logic brOnVcc;
    logic brOnExec;
  } strobeT;

endpackage

// File: rtl/lmask_ctrl.sv
module lmask_ctrl
  import lmask_pkg::*;
(
  input  logic            instValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            vccZero,
  input  logic            execZero,
  output strobeT          stb,
  output logic            branchTake
);

  always_comb begin
    stb = '0;
    if (instValid) begin
      case (opcode)
        OP_VCMP:     stb.vccLoad     = 1'b1;
        OP_SAVE:     stb.saveLoad    = 1'b1;
        OP_IFAND:    stb.execIf      = 1'b1;
        OP_ELSEANDN: stb.execElse    = 1'b1;
        OP_RESTORE:  stb.execRestore = 1'b1;
        OP_BRVCCZ:   stb.brOnVcc     = 1'b1;
        OP_BREXECZ:  stb.brOnExec    = 1'b1;
        OP_VWRITE:   stb.laneWrite   = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  assign branchTake = (stb.brOnVcc & vccZero) | (stb.brOnExec & execZero);

endmodule

// File: rtl/lmask_dp.sv
module lmask_dp
  import lmask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int GROUP = 16,
  parameter int DW    = 8,
  parameter int NSAVE = 2,
  localparam int NGRP  = LANES / GROUP,
  localparam int SEL_W = (NSAVE > 1) ? $clog2(NSAVE) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [SEL_W-1:0]    saveSel,
  input  logic [LANES-1:0]    cmpBits,
  input  logic [LANES*DW-1:0] laneData,
  output logic [LANES-1:0]    execMask,
  output logic [LANES-1:0]    vccMask,
  output logic                vccZero,
  output logic                execZero,
  output logic [LANES-1:0]    laneWbEn,
  output logic [LANES*DW-1:0] laneRegs
);

  logic [LANES-1:0] execQ, vccQ;
  logic [LANES-1:0] saveQ [NSAVE];
  logic [LANES-1:0] savedSel;
  logic [LANES-1:0] execNext;
  logic [NGRP-1:0]  grpExecAny, grpVccAny;

  assign savedSel = saveQ[saveSel];

  always_comb begin
    execNext = execQ;
    if (stb.execIf)           execNext = vccQ & execQ;
    else if (stb.execElse)    execNext = savedSel & ~execQ;
    else if (stb.execRestore) execNext = savedSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      execQ <= '1;
      vccQ  <= '0;
    end else begin
      execQ <= execNext;
      if (stb.vccLoad) vccQ <= cmpBits & execQ;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSAVE; s++) begin
      if (!rstN)
        saveQ[s] <= '0;
      else if (stb.saveLoad && (saveSel == SEL_W'(s)))
        saveQ[s] <= execQ;
    end
  end

  // per-group zero detection, one reduction per group of lanes
  for (genvar g = 0; g < NGRP; g++) begin : gGrp
    assign grpExecAny[g] = |execQ[g*GROUP +: GROUP];
    assign grpVccAny[g]  = |vccQ[g*GROUP +: GROUP];
  end

  assign execZero = ~|grpExecAny;
  assign vccZero  = ~|grpVccAny;
  assign laneWbEn = execQ & {LANES{stb.laneWrite}};

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [DW-1:0] regQ;
    always_ff @(posedge clk) begin
      if (!rstN)            regQ <= '0;
      else if (laneWbEn[l]) regQ <= laneData[l*DW +: DW];
    end
    assign laneRegs[l*DW +: DW] = regQ;
  end

  assign execMask = execQ;
  assign vccMask  = vccQ;

endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lmask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int GROUP = 16,
  parameter int DW    = 8,
  parameter int NSAVE = 2,
  localparam int SEL_W = (NSAVE > 1) ? $clog2(NSAVE) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [OP_W-1:0]     opcode,
  input  logic [SEL_W-1:0]    saveSel,
  input  logic [LANES-1:0]    cmpBits,
  input  logic [LANES*DW-1:0] laneData,
  output logic [LANES-1:0]    execMask,
  output logic [LANES-1:0]    vccMask,
  output logic                vccZero,
  output logic                execZero,
  output logic                branchTake,
  output logic [LANES-1:0]    laneWbEn,
  output logic [LANES*DW-1:0] laneRegs
);

  strobeT stb;

  lmask_ctrl u_ctrl (
    .instValid (instValid),
    .opcode    (opcode),
    .vccZero   (vccZero),
    .execZero  (execZero),
    .stb       (stb),
    .branchTake(branchTake)
  );

  lmask_dp #(.LANES(LANES), .GROUP(GROUP), .DW(DW), .NSAVE(NSAVE)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .saveSel (saveSel),
    .cmpBits (cmpBits),
    .laneData(laneData),
    .execMask(execMask),
    .vccMask (vccMask),
    .vccZero (vccZero),
    .execZero(execZero),
    .laneWbEn(laneWbEn),
    .laneRegs(laneRegs)
  );

endmodule

// File: rtl/lane_mask_chk.sv
module lane_mask_chk #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             instValid,
  input logic [3:0]       opcode,
  input logic [LANES-1:0] cmpBits,
  input logic [LANES-1:0] execMask,
  input logic [LANES-1:0] vccMask,
  input logic             branchTake,
  input logic [LANES-1:0] laneWbEn
);

  p_vcc_inside_exec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == 4'd1) |=> ((vccMask & ~$past(execMask)) == '0));

  p_if_narrows_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == 4'd3) |=> (execMask == ($past(vccMask) & $past(execMask))));

  p_branch_vcc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == 4'd6) |-> (branchTake == (vccMask == '0)));

  p_branch_exec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == 4'd7) |-> (branchTake == (execMask == '0)));

  p_wb_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((laneWbEn & ~execMask) == '0));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> ($stable(execMask) && $stable(vccMask)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!branchTake && laneWbEn == '0));

endmodule

bind lane_mask_ctrl lane_mask_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .opcode    (opcode),
  .cmpBits   (cmpBits),
  .execMask  (execMask),
  .vccMask   (vccMask),
  .branchTake(branchTake),
  .laneWbEn  (laneWbEn)
);

// File: tb/test_lane_mask_ctrl.sv
module test_lane_mask_ctrl;

  localparam int L  = 64;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instValid = 1'b0;
  logic [3:0]      opcode = '0;
  logic [0:0]      saveSel = '0;
  logic [L-1:0]    cmpBits = '0;
  logic [L*DW-1:0] laneData = '0;
  logic [L-1:0]    execMask, vccMask, laneWbEn;
  logic            vccZero, execZero, branchTake;
  logic [L*DW-1:0] laneRegs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [L-1:0]    mExec, mVcc;
  logic [L-1:0]    mSave [2];
  logic [L*DW-1:0] mRegs;

  always #2 clk = ~clk;

  lane_mask_ctrl i_lane_mask_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(opcode),
    .saveSel(saveSel), .cmpBits(cmpBits), .laneData(laneData),
    .execMask(execMask), .vccMask(vccMask), .vccZero(vccZero),
    .execZero(execZero), .branchTake(branchTake), .laneWbEn(laneWbEn),
    .laneRegs(laneRegs)
  );

  task automatic chk(string req, logic [L*DW-1:0] act, logic [L*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic expBranch(logic v, logic [3:0] op, logic [L-1:0] ex, logic [L-1:0] vc);
    if (!v) return 1'b0;
    if (op == 4'd6) return (vc == '0);
    if (op == 4'd7) return (ex == '0);
    return 1'b0;
  endfunction

  function automatic logic [L-1:0] expWb(logic v, logic [3:0] op, logic [L-1:0] ex);
    return (v && op == 4'd8) ? ex : '0;
  endfunction

  function automatic logic [L-1:0] expExec(logic v, logic [3:0] op, logic [L-1:0] ex,
                                           logic [L-1:0] vc, logic [L-1:0] sv);
    if (!v) return ex;
    case (op)
      4'd3: return vc & ex;
      4'd4: return sv & ~ex;
      4'd5: return sv;
      default: return ex;
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R11";
    endcase
  endfunction

  // entered just after a falling edge
  task automatic doInst(logic v, logic [3:0] op, logic sel, logic [L-1:0] cmp, logic [L*DW-1:0] dat);
    logic [L-1:0] nExec, nVcc;
    string r;
    r = reqOf(op);
    instValid = v; opcode = op; saveSel = sel; cmpBits = cmp; laneData = dat;
    #1;
    chk({r, " branchTake"}, L*DW'(branchTake), L*DW'(expBranch(v, op, mExec, mVcc)));
    chk({r, " laneWbEn"}, L*DW'(laneWbEn), L*DW'(expWb(v, op, mExec)));
    nExec = expExec(v, op, mExec, mVcc, mSave[sel]);
    nVcc  = (v && op == 4'd1) ? (cmp & mExec) : mVcc;
    if (v && op == 4'd2) mSave[sel] = mExec;
    if (v && op == 4'd8)
      for (int i = 0; i < L; i++)
        if (mExec[i]) mRegs[i*DW +: DW] = dat[i*DW +: DW];
    mExec = nExec; mVcc = nVcc;
    @(posedge clk); #1;
    chk({r, " execMask"}, L*DW'(execMask), L*DW'(mExec));
    chk({r, " vccMask"}, L*DW'(vccMask), L*DW'(mVcc));
    chk("R10 flags", L*DW'({vccZero, execZero}), L*DW'({mVcc == '0, mExec == '0}));
    chk({r, " laneRegs"}, laneRegs, mRegs);
    instValid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [L*DW-1:0] rndData();
    logic [L*DW-1:0] d;
    for (int i = 0; i < L*DW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    #(4*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedV;
    logic [L-1:0] a;
    seedV = $urandom(32'h5eed);
    mExec = '1; mVcc = '0; mSave[0] = '0; mSave[1] = '0; mRegs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 execMask", L*DW'(execMask), L*DW'({L{1'b1}}));
    chk("R1 vccMask", L*DW'(vccMask), '0);
    chk("R1 laneRegs", laneRegs, '0);
    chk("R10 reset flags", L*DW'({vccZero, execZero}), L*DW'(2'b10));
    @(negedge clk);

    // directed: no lane passes -> "if" skipped (R7), all lanes go "else"
    doInst(1, 4'd1, 0, '0, '0);
    doInst(1, 4'd2, 0, '0, '0);
    doInst(1, 4'd3, 0, '0, '0);
    doInst(1, 4'd6, 0, '0, '0);
    doInst(1, 4'd4, 0, '0, '0);
    doInst(1, 4'd7, 0, '0, '0);
    doInst(1, 4'd8, 0, '0, rndData());
    doInst(1, 4'd5, 0, '0, '0);
    // directed: every lane passes -> "else" empty (R8)
    doInst(1, 4'd1, 0, '1, '0);
    doInst(1, 4'd2, 0, '0, '0);
    doInst(1, 4'd3, 0, '0, '0);
    doInst(1, 4'd6, 0, '0, '0);
    doInst(1, 4'd4, 0, '0, '0);
    doInst(1, 4'd7, 0, '0, '0);
    doInst(1, 4'd8, 0, '0, rndData());
    doInst(1, 4'd5, 0, '0, '0);
    // directed nesting with both slots (R12)
    a = {$urandom, $urandom};
    doInst(1, 4'd1, 0, a, '0);
    doInst(1, 4'd2, 0, '0, '0);
    doInst(1, 4'd3, 0, '0, '0);
    doInst(1, 4'd1, 0, {$urandom, $urandom}, '0);
    doInst(1, 4'd2, 1, '0, '0);
    doInst(1, 4'd3, 0, '0, '0);
    doInst(1, 4'd8, 0, '0, rndData());
    doInst(1, 4'd4, 1, '0, '0);
    doInst(1, 4'd8, 0, '0, rndData());
    doInst(1, 4'd5, 1, '0, '0);
    doInst(1, 4'd4, 0, '0, '0);
    doInst(1, 4'd5, 0, '0, '0);
    // R11 idle and undefined opcodes
    doInst(0, 4'd3, 0, '0, rndData());
    doInst(1, 4'd0, 0, '1, rndData());
    doInst(1, 4'd12, 1, '1, rndData());

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 11));
      doInst(($urandom_range(0, 7) != 0), op, 1'($urandom), {$urandom, $urandom}, rndData());
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule